// File: doc/BRIEF.md
# Display Line Capture Writer

This block copies finished scanlines of rendered video into one of four memory banks while the display is in the blank part of each line. It is armed once per frame: the enable bit of its 32-bit control word is sampled when line 0 begins, and the block itself clears that bit when the visible area ends. A pixel then gets into memory only if three conditions all hold: the block was armed at line 0, the target bank is in direct processor-view mode, and the current line falls inside the selected capture size. Captured pixels leave the block as 15-bit colour in halfword writes.

A display timing generator drives the line-start pulse with the line number and later the blank-start pulse for that line. The renderer then streams 24-bit pixels with a valid strobe. Software writes the control word through the configuration port and can read it back on `ctrl_q`. The bank-mode logic supplies one processor-view flag per bank.

Top module: `cap_writer`

## Requirements
- R1: After reset `ctrl_q` is 0, `wr_en` is 0, `line_done` is 0, and the block is not armed.
- R2: A configuration write stores `cfg_wdata` in the control word, which shows on `ctrl_q` in the next cycle.
- R3: The enable bit is control bit 31. It is sampled only at a line-start pulse with line number 0. Setting it later in the frame has no effect until the next line 0.
- R4: A line-start pulse with line number VIS_LINES (192) clears control bit 31 and disarms the block. If a configuration write lands in the same cycle, its other bits are stored and bit 31 still reads 0.
- R5: The destination bank is chosen by control bits 17:16. A line is captured only if `bank_cpu_view[bank]` is 1 at blank start. Otherwise nothing is written.
- R6: The size code sits in control bits 21:20. Code 0 writes 128 pixels per line. Codes 1, 2 and 3 write 256 pixels per line, but only on lines below 64, 128 and 192 respectively. Code 0 also applies the limit of 192 lines.
- R7: `wr_addr` is a halfword address, `{bank, in_bank}`. `in_bank` is (offset·16384 + line·256 + x) mod 65536, where offset is control bits 19:18 and x is the pixel index within the line.
- R8: `wr_data` is `{1'b0, p[23:19], p[15:11], p[7:3]}` for a 24-bit pixel p.
- R9: Each accepted pixel gives exactly one write, one cycle after its valid strobe. Pixels past the line width are ignored. `line_done` pulses together with the last write of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| ctrl_q | output | 32 | Current control word |
| line_start | input | 1 | Start-of-line pulse |
| line_num | input | 9 | Number of the line that is starting |
| blank_start | input | 1 | Start of the blank phase of the current line |
| bank_cpu_view | input | 4 | Per-bank flag: bank is in direct processor-view mode |
| px_valid | input | 1 | Pixel strobe |
| px_data | input | 24 | Pixel, 8 bits per channel |
| wr_en | output | 1 | Halfword write strobe |
| wr_addr | output | 18 | Halfword write address |
| wr_data | output | 16 | Halfword write data |
| line_done | output | 1 | Pulse with the last write of a captured line |

## Verification
The hardware clear of the enable bit at the end of the visible area can fall in the same cycle as a software write of the control word. The bench provokes this by raising `cfg_we` with bit 31 set in the very cycle of the line-192 pulse. It then expects `ctrl_q` to hold every written field except bit 31, and it expects the following frame to produce no writes. A second overlap is also exercised: a write that sets the enable just after line 0 must not arm the current frame.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int EN_BIT   = 31;
    localparam int BLK_LSB  = 16;
    localparam int SEG_LSB  = 18;
    localparam int SIZE_LSB = 20;

    typedef enum logic [1:0] {
        SZ_HALF = 2'd0,
        SZ_Q64  = 2'd1,
        SZ_Q128 = 2'd2,
        SZ_FULL = 2'd3
    } cap_size_e;

    typedef struct packed {
        logic [1:0] blk;
        logic [1:0] seg;
        cap_size_e  size;
    } cap_cfg_t;

    function automatic cap_cfg_t decode_cfg(input logic [31:0] w);
        cap_cfg_t c;
        c.blk  = w[BLK_LSB +: 2];
        c.seg  = w[SEG_LSB +: 2];
        c.size = cap_size_e'(w[SIZE_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [14:0] pack15(input logic [23:0] p);
        return {p[23:19], p[15:11], p[7:3]};
    endfunction

    function automatic logic line_ok(input cap_size_e s, input int unsigned y,
                                     input int unsigned lim_a, input int unsigned lim_b,
                                     input int unsigned vis);
        case (s)
            SZ_Q64:  return y < lim_a;
            SZ_Q128: return y < lim_b;
            default: return y < vis;
        endcase
    endfunction

endpackage

// File: rtl/cap_ctrl_reg.sv
module cap_ctrl_reg #(
    parameter int LINE_W    = 9,
    parameter int VIS_LINES = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    output logic [31:0]       ctrl_q,
    output logic              armed,
    output logic [LINE_W-1:0] cur_line
);
    import cap_pkg::*;

    logic        at_top;
    logic        at_vblank;
    logic [31:0] ctrl_next;

    assign at_top    = line_start && (line_num == '0);
    assign at_vblank = line_start && (line_num == LINE_W'(VIS_LINES));

    always_comb begin
        ctrl_next = cfg_we ? cfg_wdata : ctrl_q;
        if (at_vblank) ctrl_next[EN_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            armed    <= 1'b0;
            cur_line <= '0;
        end else begin
            ctrl_q <= ctrl_next;
            if (line_start) cur_line <= line_num;
            if (at_top)         armed <= ctrl_q[EN_BIT];
            else if (at_vblank) armed <= 1'b0;
        end
    end

    p_arm_sample_r3: assert property (@(posedge clk) disable iff (rst)
        (line_start && line_num == '0) |=> (armed == $past(ctrl_q[EN_BIT])));

    p_vblank_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (line_start && line_num == LINE_W'(VIS_LINES)) |=> (!ctrl_q[EN_BIT] && !armed));

endmodule

// File: rtl/cap_line_seq.sv
module cap_line_seq #(
    parameter int LINE_W       = 9,
    parameter int PIX_PER_LINE = 256,
    parameter int VIS_LINES    = 192,
    parameter int LIM_A        = 64,
    parameter int LIM_B        = 128,
    localparam int XW          = $clog2(PIX_PER_LINE)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                blank_start,
    input  logic                armed,
    input  logic [31:0]         ctrl_q,
    input  logic [LINE_W-1:0]   cur_line,
    input  logic [3:0]          bank_cpu_view,
    input  logic                px_valid,
    output logic                accept,
    output logic                last_px,
    output logic [XW-1:0]       x_cnt,
    output cap_pkg::cap_cfg_t   snap_cfg,
    output logic [LINE_W-1:0]   snap_line
);
    import cap_pkg::*;

    cap_cfg_t      live_cfg;
    logic          busy;
    logic          start_ok;
    logic [XW-1:0] width_m1;

    assign live_cfg = decode_cfg(ctrl_q);
    assign start_ok = armed && bank_cpu_view[live_cfg.blk] &&
                      line_ok(live_cfg.size, 32'(cur_line), LIM_A, LIM_B, VIS_LINES);
    assign width_m1 = (snap_cfg.size == SZ_HALF) ? XW'(PIX_PER_LINE / 2 - 1)
                                                 : XW'(PIX_PER_LINE - 1);
    assign accept   = busy && px_valid;
    assign last_px  = (x_cnt == width_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            x_cnt     <= '0;
            snap_cfg  <= '0;
            snap_line <= '0;
        end else if (blank_start) begin
            busy      <= start_ok;
            x_cnt     <= '0;
            snap_cfg  <= live_cfg;
            snap_line <= cur_line;
        end else if (accept) begin
            x_cnt <= x_cnt + 1'b1;
            if (last_px) busy <= 1'b0;
        end
    end

    p_no_start_without_view_r5: assert property (@(posedge clk) disable iff (rst)
        (blank_start && !bank_cpu_view[live_cfg.blk]) |=> !busy);

    p_x_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (x_cnt <= width_m1));

endmodule

// File: rtl/cap_pixel_fmt.sv
module cap_pixel_fmt #(
    parameter int LINE_W       = 9,
    parameter int PIX_PER_LINE = 256,
    parameter int BANK_HW      = 65536,
    parameter int SEG_HW       = 16384,
    localparam int XW          = $clog2(PIX_PER_LINE),
    localparam int BANK_AW     = $clog2(BANK_HW),
    localparam int ADDR_W      = BANK_AW + 2,
    localparam int SEG_SH      = $clog2(SEG_HW),
    localparam int LINE_SH     = $clog2(PIX_PER_LINE)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                last_px,
    input  logic [XW-1:0]       x_cnt,
    input  cap_pkg::cap_cfg_t   snap_cfg,
    input  logic [LINE_W-1:0]   snap_line,
    input  logic [23:0]         px_data,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [15:0]         wr_data,
    output logic                line_done
);
    import cap_pkg::*;

    logic [BANK_AW-1:0] in_bank;

    assign in_bank = (BANK_AW'(snap_cfg.seg) << SEG_SH)
                   + (BANK_AW'(snap_line) << LINE_SH)
                   + BANK_AW'(x_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            line_done <= 1'b0;
        end else begin
            wr_en     <= accept;
            line_done <= accept && last_px;
            if (accept) begin
                wr_addr <= {snap_cfg.blk, in_bank};
                wr_data <= {1'b0, pack15(px_data)};
            end
        end
    end

    p_done_with_write_r9: assert property (@(posedge clk) disable iff (rst)
        line_done |-> wr_en);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en) && !$past(line_done)) |->
        (wr_addr[BANK_AW-1:0] == $past(wr_addr[BANK_AW-1:0]) + 1'b1 &&
         wr_addr[ADDR_W-1:BANK_AW] == $past(wr_addr[ADDR_W-1:BANK_AW])));

endmodule

// File: rtl/cap_writer.sv
module cap_writer #(
    parameter int LINE_W       = 9,
    parameter int PIX_PER_LINE = 256,
    parameter int VIS_LINES    = 192,
    parameter int LIM_A        = 64,
    parameter int LIM_B        = 128,
    parameter int BANK_HW      = 65536,
    parameter int SEG_HW       = 16384,
    localparam int XW          = $clog2(PIX_PER_LINE),
    localparam int ADDR_W      = $clog2(BANK_HW) + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       ctrl_q,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              blank_start,
    input  logic [3:0]        bank_cpu_view,
    input  logic              px_valid,
    input  logic [23:0]       px_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    output logic              line_done
);
    import cap_pkg::*;

    logic              armed;
    logic [LINE_W-1:0] cur_line;
    logic              accept;
    logic              last_px;
    logic [XW-1:0]     x_cnt;
    cap_cfg_t          snap_cfg;
    logic [LINE_W-1:0] snap_line;

    cap_ctrl_reg #(.LINE_W(LINE_W), .VIS_LINES(VIS_LINES)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .line_start(line_start), .line_num(line_num),
        .ctrl_q(ctrl_q), .armed(armed), .cur_line(cur_line)
    );

    cap_line_seq #(.LINE_W(LINE_W), .PIX_PER_LINE(PIX_PER_LINE), .VIS_LINES(VIS_LINES),
                   .LIM_A(LIM_A), .LIM_B(LIM_B)) u_seq (
        .clk(clk), .rst(rst), .blank_start(blank_start), .armed(armed),
        .ctrl_q(ctrl_q), .cur_line(cur_line), .bank_cpu_view(bank_cpu_view),
        .px_valid(px_valid), .accept(accept), .last_px(last_px), .x_cnt(x_cnt),
        .snap_cfg(snap_cfg), .snap_line(snap_line)
    );

    cap_pixel_fmt #(.LINE_W(LINE_W), .PIX_PER_LINE(PIX_PER_LINE), .BANK_HW(BANK_HW),
                    .SEG_HW(SEG_HW)) u_fmt (
        .clk(clk), .rst(rst), .accept(accept), .last_px(last_px), .x_cnt(x_cnt),
        .snap_cfg(snap_cfg), .snap_line(snap_line), .px_data(px_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .line_done(line_done)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!wr_en && !line_done && ctrl_q == '0));

endmodule

// File: tb/tb_cap_writer.sv
`timescale 1ns/1ps
module tb_cap_writer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ctrl_q;
    logic        line_start = 1'b0;
    logic [8:0]  line_num = '0;
    logic        blank_start = 1'b0;
    logic [3:0]  bank_cpu_view = 4'hF;
    logic        px_valid = 1'b0;
    logic [23:0] px_data = '0;
    logic        wr_en;
    logic [17:0] wr_addr;
    logic [15:0] wr_data;
    logic        line_done;

    always #2.5 clk = ~clk;

    cap_writer dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q),
        .line_start(line_start), .line_num(line_num), .blank_start(blank_start),
        .bank_cpu_view(bank_cpu_view), .px_valid(px_valid), .px_data(px_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .line_done(line_done)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [3:0]  view;
        logic [8:0]  line;
        logic [23:0] base;
        logic [8:0]  n;
        logic [17:0] first;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{32'h80300000, 4'hF, 9'd5,   24'h123456, 9'd256, 18'd1280},
        '{32'h80090000, 4'hF, 9'd10,  24'hFFFFFF, 9'd128, 18'd100864},
        '{32'h80160000, 4'hF, 9'd63,  24'h0807F0, 9'd256, 18'd163584},
        '{32'h80160000, 4'hF, 9'd64,  24'h0807F0, 9'd0,   18'd0},
        '{32'h802C0000, 4'hF, 9'd127, 24'hA5C3E1, 9'd256, 18'd16128},
        '{32'h802C0000, 4'hF, 9'd128, 24'hA5C3E1, 9'd0,   18'd0},
        '{32'h803F0000, 4'hF, 9'd191, 24'h00FF00, 9'd256, 18'd229120},
        '{32'h80310000, 4'hD, 9'd20,  24'h777777, 9'd0,   18'd0},
        '{32'h80030000, 4'hF, 9'd191, 24'hF80000, 9'd128, 18'd245504}
    };

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    int          nw, ndone;
    logic [17:0] first_a, last_a, done_a;
    logic [15:0] first_d;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                if (nw == 0) begin
                    first_a = wr_addr;
                    first_d = wr_data;
                end
                last_a = wr_addr;
                nw++;
            end
            if (line_done) begin
                ndone++;
                done_a = wr_addr;
            end
        end
    end

    function automatic logic [15:0] conv(input logic [23:0] p);
        return {1'b0, p[23:19], p[15:11], p[7:3]};
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_line(input logic [8:0] n);
        line_start = 1'b1; line_num = n;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic run_line(input logic [8:0] n, input logic [23:0] base);
        pulse_line(n);
        nw = 0; ndone = 0;
        blank_start = 1'b1;
        @(negedge clk);
        blank_start = 1'b0;
        for (int i = 0; i < 260; i++) begin
            px_valid = 1'b1;
            px_data  = base + 24'(i);
            @(negedge clk);
        end
        px_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 ctrl_q", ctrl_q, 32'h0);
        check("R1 wr_en", 32'(wr_en), 32'h0);
        check("R1 line_done", 32'(line_done), 32'h0);
        run_line(9'd5, 24'h0);
        check("R1 no capture while unarmed", nw, 0);

        // R2: read back of control word
        wr_ctrl(32'h00300000);
        check("R2 ctrl readback", ctrl_q, 32'h00300000);

        // table walk: R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            bank_cpu_view = TBL[v].view;
            wr_ctrl(TBL[v].ctrl);
            pulse_line(9'd0);
            run_line(TBL[v].line, TBL[v].base);
            check($sformatf("R5/R6 write count vec%0d", v), nw, 32'(TBL[v].n));
            if (TBL[v].n != 0) begin
                check($sformatf("R7 first addr vec%0d", v), 32'(first_a), 32'(TBL[v].first));
                check($sformatf("R7 last addr vec%0d", v), 32'(last_a),
                      32'(TBL[v].first) + 32'(TBL[v].n) - 1);
                check($sformatf("R8 first data vec%0d", v), 32'(first_d), 32'(conv(TBL[v].base)));
                check($sformatf("R9 done count vec%0d", v), ndone, 1);
                check($sformatf("R9 done on last write vec%0d", v), 32'(done_a), 32'(last_a));
            end else begin
                check($sformatf("R9 no done vec%0d", v), ndone, 0);
            end
        end
        bank_cpu_view = 4'hF;

        // R3: enable set after line 0 does not arm this frame
        wr_ctrl(32'h00300000);
        pulse_line(9'd0);
        wr_ctrl(32'h80300000);
        run_line(9'd5, 24'h111111);
        check("R3 late enable ignored", nw, 0);
        pulse_line(9'd0);
        run_line(9'd5, 24'h111111);
        check("R3 enable taken at next line 0", nw, 256);

        // R4: clear at end of visible area
        pulse_line(9'd192);
        check("R4 enable bit cleared", ctrl_q, 32'h00300000);
        run_line(9'd6, 24'h222222);
        check("R4 disarmed after vblank", nw, 0);

        // R4: collision of software write with hardware clear
        cfg_we = 1'b1; cfg_wdata = 32'h803F0000;
        line_start = 1'b1; line_num = 9'd192;
        @(negedge clk);
        cfg_we = 1'b0; line_start = 1'b0;
        check("R4 collision keeps fields, clears enable", ctrl_q, 32'h003F0000);
        pulse_line(9'd0);
        run_line(9'd5, 24'h333333);
        check("R4 collision leaves frame unarmed", nw, 0);

        finish_run();
    end

endmodule